// File: doc/BRIEF.md
# Dual-Channel Registered Drive-Strength Decoder

This block sets the strength of a segmented gate driver. It takes two binary strength codes, one for the source side and one for the sink side, and samples both on the same clock edge. Each code becomes a row of enables with as many ones as the code's value, filled from bit 0 upward. A controller sets the strength once per clock step by presenting a new pair of codes, so a gate current profile is built step by step.

The binary-to-row expansion sits in front of the output flops. The enable rows are therefore taken straight from register bits and update once per edge. A code step that crosses a power of two, such as 31 to 32, cannot show a brief pattern with far too many drivers on. An optional guard, built in through a parameter and armed by an input, prevents source and sink from being enabled together. When it triggers, it clears both rows and sets a fault flag that stays set until reset.

Top module: `dual_therm_drive`

## Requirements
- R1: While `rst_n` is low, both enable rows and `fault` are zero, whatever the codes. Reset also clears a `fault` that was set earlier.
- R2: For a captured code N, bit i of the row (bit 0 first) is 1 exactly when i < N. Code 0 gives all 63 bits low and code 63 gives all 63 bits high.
- R3: Both codes are sampled at the same rising edge, and the rows show the result after that edge. Between edges the rows hold, even when the codes change.
- R4: After every edge, the number of ones in each row equals the code sampled at that edge, unless R5 blocks it.
- R5: With `GUARD_EN`=1, if `lock_en` is high and both codes are nonzero at an edge, both rows are all zero after that edge.
- R6: `fault` goes high at the first edge where R5 blocks. It then stays high, with any later inputs, until reset.
- R7: With `lock_en` low, both rows may be nonzero at once and follow their codes as in R2.
- R8: A step across a power-of-two boundary (31 to 32, 32 to 31, 0 to 63, 63 to 0) moves the row from the old pattern to the new one in a single edge.
- R9: With `GUARD_EN`=0, `lock_en` has no effect and `fault` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; codes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Arms the source/sink overlap guard |
| up_code | input | CODE_W (6) | Binary count of source drivers to enable |
| dn_code | input | CODE_W (6) | Binary count of sink drivers to enable |
| up_en | output | 2**CODE_W-1 (63) | Registered source enable row |
| dn_en | output | 2**CODE_W-1 (63) | Registered sink enable row |
| fault | output | 1 | Sticky flag: an overlap was blocked |

## Verification
The bench builds two copies at the default width of 6 bits (63 lanes), with the same inputs. In `u0` the guard is built in (`GUARD_EN`=1), so blocking and the sticky flag can be tested. In `u1` it is left out (`GUARD_EN`=0), so the same overlapping, armed stimulus shows that `lock_en` is ignored there. Full width lets the bench sweep every code on both channels and reach both ends of the row and the 31/32 boundary.

// File: rtl/drv_pkg.sv
package drv_pkg;
  typedef enum int unsigned {SIDE_UP = 0, SIDE_DN = 1} side_e;
  localparam int unsigned NUM_SIDES = 2;

  // Lane idx is switched on when the code counts past it.
  function automatic logic lane_on(input int unsigned code, input int unsigned idx);
    return code > idx;
  endfunction

  // True when both sides ask for at least one driver.
  function automatic logic both_active(input int unsigned a, input int unsigned b);
    return (a != 0) && (b != 0);
  endfunction
endpackage

// File: rtl/therm_decoder.sv
module therm_decoder #(
  parameter int unsigned CODE_W = 6,
  localparam int unsigned LANES = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [LANES-1:0]  row
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign row[i] = drv_pkg::lane_on(int'(code), i);
  end
endmodule

// File: rtl/lane_reg.sv
module lane_reg #(
  parameter int unsigned WIDTH = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else            q <= d;
  end
endmodule

// File: rtl/shoot_guard.sv
module shoot_guard #(
  parameter int unsigned CODE_W   = 6,
  parameter bit          GUARD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic [CODE_W-1:0] up_code,
  input  logic [CODE_W-1:0] dn_code,
  output logic              block,
  output logic              fault
);
  logic collide;
  assign collide = drv_pkg::both_active(int'(up_code), int'(dn_code));
  assign block   = GUARD_EN && lock_en && collide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fault <= 1'b0;
    else if (block) fault <= 1'b1;
  end
endmodule

// File: rtl/dual_therm_drive.sv
module dual_therm_drive #(
  parameter int unsigned CODE_W   = 6,
  parameter bit          GUARD_EN = 1'b1,
  localparam int unsigned LANES   = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic [CODE_W-1:0] up_code,
  input  logic [CODE_W-1:0] dn_code,
  output logic [LANES-1:0]  up_en,
  output logic [LANES-1:0]  dn_en,
  output logic              fault
);
  import drv_pkg::*;

  logic              block_now;
  logic [CODE_W-1:0] code_a [NUM_SIDES];
  logic [LANES-1:0]  dec_a  [NUM_SIDES];
  logic [LANES-1:0]  q_a    [NUM_SIDES];

  assign code_a[SIDE_UP] = up_code;
  assign code_a[SIDE_DN] = dn_code;

  shoot_guard #(.CODE_W(CODE_W), .GUARD_EN(GUARD_EN)) u_guard (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en),
    .up_code(up_code), .dn_code(dn_code),
    .block(block_now), .fault(fault)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    therm_decoder #(.CODE_W(CODE_W)) u_dec (.code(code_a[s]), .row(dec_a[s]));
    lane_reg #(.WIDTH(LANES)) u_reg (
      .clk(clk), .rst_n(rst_n), .clear(block_now), .d(dec_a[s]), .q(q_a[s])
    );
  end

  assign up_en = q_a[SIDE_UP];
  assign dn_en = q_a[SIDE_DN];
endmodule

// File: rtl/drive_checker.sv
module drive_checker #(
  parameter int unsigned CODE_W   = 6,
  parameter bit          GUARD_EN = 1'b1,
  localparam int unsigned LANES   = (1 << CODE_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_en,
  input logic [CODE_W-1:0] up_code,
  input logic [CODE_W-1:0] dn_code,
  input logic [LANES-1:0]  up_en,
  input logic [LANES-1:0]  dn_en,
  input logic              fault,
  input logic              block_now
);
  assert_shape_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en & (up_en + LANES'(1))) == '0);
  assert_shape_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_en & (dn_en + LANES'(1))) == '0);

  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(up_en) == ($past(block_now) ? 0 : int'($past(up_code))));
  assert_count_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(dn_en) == ($past(block_now) ? 0 : int'($past(dn_code))));

  assert_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    block_now |=> (up_en == '0) && (dn_en == '0) && fault);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> ((up_en != '0) == ($past(up_code) != '0)) &&
                 ((dn_en != '0) == ($past(dn_code) != '0)));

  assert_noguard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (GUARD_EN != 1'b0) || !fault);
endmodule

bind dual_therm_drive drive_checker #(.CODE_W(CODE_W), .GUARD_EN(GUARD_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_en(lock_en),
  .up_code(up_code), .dn_code(dn_code),
  .up_en(up_en), .dn_en(dn_en), .fault(fault), .block_now(block_now)
);

// File: tb/sim_dual_therm_drive.sv
module sim_dual_therm_drive;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_en = 1'b0;
  logic [5:0] up_code = '0, dn_code = '0;
  logic [62:0] up0, dn0, up1, dn1;
  logic f0, f1;
  int compared = 0, mismatched = 0;
  logic [62:0] e_up0 = '0, e_dn0 = '0, e_up1 = '0, e_dn1 = '0;
  logic e_f0 = 1'b0;

  always #4 clk = ~clk;

  dual_therm_drive #(.CODE_W(6), .GUARD_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .up_code(up_code),
    .dn_code(dn_code), .up_en(up0), .dn_en(dn0), .fault(f0));
  dual_therm_drive #(.CODE_W(6), .GUARD_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .up_code(up_code),
    .dn_code(dn_code), .up_en(up1), .dn_en(dn1), .fault(f1));

  function automatic logic [62:0] ref_row(int n);
    logic [62:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [62:0] act, logic [62:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "u0.up_en", up0, e_up0);
    chk(tag, "u0.dn_en", dn0, e_dn0);
    chk("R6", "u0.fault", 63'(f0), 63'(e_f0));
    chk(tag, "u1.up_en", up1, e_up1);
    chk(tag, "u1.dn_en", dn1, e_dn1);
    chk("R9", "u1.fault", 63'(f1), 63'd0);
  endtask

  // Drive just after a falling edge; model one rising edge; compare at the next fall.
  task automatic apply(int u, int d, bit l, string tag);
    bit blk;
    up_code = 6'(u); dn_code = 6'(d); lock_en = l;
    @(posedge clk);
    blk   = l && (u > 0) && (d > 0);
    e_up1 = ref_row(u);
    e_dn1 = ref_row(d);
    e_up0 = blk ? '0 : e_up1;
    e_dn0 = blk ? '0 : e_dn1;
    e_f0  = e_f0 | blk;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    up_code = 6'd40; dn_code = 6'd9; lock_en = 1'b1;
    repeat (2) @(negedge clk);
    e_up0 = '0; e_dn0 = '0; e_up1 = '0; e_dn1 = '0; e_f0 = 1'b0;
    compare_all("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    apply(0, 0, 1'b0, "R2");
    apply(63, 0, 1'b0, "R2");
    apply(0, 63, 1'b0, "R2");
    // R8: steps across power-of-two boundaries
    apply(31, 32, 1'b0, "R8");
    apply(32, 31, 1'b0, "R8");
    apply(31, 32, 1'b0, "R8");
    apply(0, 63, 1'b0, "R8");
    apply(63, 0, 1'b0, "R8");
    // R4 and R7: sweep every code on both sides, unguarded
    for (int n = 0; n < 64; n++) apply(n, 63 - n, 1'b0, "R4");
    apply(17, 45, 1'b0, "R7");
    // R3: codes move between edges, rows must hold
    up_code = 6'd3; dn_code = 6'd60; #2;
    compare_all("R3");
    apply(3, 60, 1'b0, "R3");
    // R5: armed guard with one side idle passes, with both active blocks
    apply(5, 0, 1'b1, "R5");
    apply(0, 12, 1'b1, "R5");
    apply(5, 7, 1'b1, "R5");
    apply(63, 63, 1'b1, "R5");
    // R6: flag stays set after overlap clears and guard is disarmed
    apply(0, 0, 1'b0, "R6");
    apply(20, 30, 1'b0, "R6");
    apply(1, 1, 1'b1, "R5");
    // R1: reset clears the latched flag
    do_reset();
    apply(8, 0, 1'b1, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule